// File: doc/BRIEF.md
# Branch Target and Condition Unit

This unit picks the next program counter for a small controller with 12-bit code addresses. The fetch stage presents one instruction for one cycle with `valid`. It supplies the opcode, the second instruction byte, the address of the following instruction, the accumulator, a scratch register value and the status and pin inputs. One cycle later the unit returns the chosen program counter with `done`. It also raises `taken` when the flow leaves the fall-through path. The unit covers these instruction forms:

- conditional short jumps, whose target stays inside the current 256-byte page
- accumulator bit tests
- the decrement-and-branch loop instruction
- long jumps and calls, which take their top address bit from a latched bank bit
- a page-indirect jump

The page-indirect jump and the table read from page 3 both use a synchronous program-memory read port. For these two, the answer arrives two cycles after acceptance, and any `valid` seen during the wait cycle is dropped. The unit also holds a timer-overflow flag. The flag is set by a pulse input and cleared when a jump tests it.

Top module: `branch_target_unit`

## Requirements
- R1: After reset, `done`, `bank`, `tf_flag` and `pmem_rd` are all 0.
- R2: An accepted opcode with low nibble 6 tests a condition picked by its high nibble. The codes are:
  - 1 timer flag set
  - 2 `t0_pin`=0
  - 3 `t0_pin`=1
  - 4 `t1_pin`=0
  - 5 `t1_pin`=1
  - 7 `f1`=1
  - 8 `int_pin`=0
  - 9 `acc`≠0
  - B `f0`=1
  - C `acc`=0
  - E `carry`=0
  - F `carry`=1

  One cycle after acceptance, `done` is 1. `pc_out` is {`next_pc`[11:8], `operand`} with `taken`=1 when the condition holds; otherwise `pc_out` is `next_pc` with `taken`=0.
- R3: An opcode with low nibble 2 and bit 4 set tests `acc` bit opcode[7:5]. When that bit is 1, the unit takes the in-page target of R2.
- R4: Opcodes E8 to EF give `djnz_wr`=1 and `djnz_val`=`reg_val`−1, modulo 256. The in-page branch is taken when `djnz_val`≠0.
- R5: An opcode with low nibble 4 always jumps to {`bank`, opcode[7:5], `operand`}. `is_call` is 1 when opcode bit 4 is 1 and 0 when it is 0.
- R6: Opcode E5 clears `bank` and opcode F5 sets it, visible with the `done` of that instruction. Each completes with `pc_out`=`next_pc`; no other opcode changes `bank`.
- R7: Opcode B3 raises `pmem_rd` in its accept cycle, with `pmem_addr`={`next_pc`[11:8], `acc`}. Two cycles after acceptance, `done` is 1 and `pc_out` is {`next_pc`[11:8], byte read}, with `taken`=1.
- R8: Opcode E3 reads `pmem_addr`={4'h3, `acc`}. Two cycles after acceptance, the unit outputs the byte on `tbl_data` with `tbl_wr`=1, `pc_out`=`next_pc` and `taken`=0.
- R9: A `tf_set` pulse sets `tf_flag` from the next cycle. An accepted opcode 16 clears it, and the jump uses the flag value from before that cycle. If `tf_set` coincides with opcode 16, the jump sees the old flag and `tf_flag` ends at 1.
- R10: Any other opcode (for example 00, 06, 83) completes with `pc_out`=`next_pc`, `taken`=0, `is_call`=0 and no write strobe.
- R11: A `valid` during the wait cycle of R7 or R8 is ignored: it gives no `pmem_rd` and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid | input | 1 | Instruction present this cycle |
| opcode | input | 8 | First instruction byte |
| operand | input | 8 | Second instruction byte |
| next_pc | input | 12 | Address following the instruction |
| acc | input | 8 | Accumulator value |
| reg_val | input | 8 | Loop register value for decrement-and-branch |
| carry | input | 1 | Carry flag |
| f0 | input | 1 | User flag 0 |
| f1 | input | 1 | User flag 1 |
| t0_pin | input | 1 | Test input 0 |
| t1_pin | input | 1 | Test input 1 |
| int_pin | input | 1 | Interrupt input level |
| tf_set | input | 1 | Timer overflow pulse |
| pmem_data | input | 8 | Program memory read data, one cycle after `pmem_rd` |
| pmem_addr | output | 12 | Program memory read address |
| pmem_rd | output | 1 | Program memory read strobe |
| done | output | 1 | Result valid pulse |
| pc_out | output | 12 | Next program counter |
| taken | output | 1 | Flow left the fall-through path |
| is_call | output | 1 | Result is a call |
| djnz_wr | output | 1 | Write strobe for the decremented register |
| djnz_val | output | 8 | Decremented register value |
| tbl_wr | output | 1 | Write strobe for the table byte |
| tbl_data | output | 8 | Byte read from page 3 |
| bank | output | 1 | Latched upper-bank bit for long targets |
| tf_flag | output | 1 | Timer overflow flag |

## Verification
Two collisions matter here, and the bench provokes both on purpose.

The timer-flag test jump can land in the same cycle as a new overflow pulse. The bench drives opcode 16 and `tf_set` together with the flag clear. It then expects a not-taken result and a flag left at 1. A second test jump then confirms the flag is consumed.

The memory-read wait cycle can also collide with a fresh `valid`. The bench offers a long jump during that cycle. It expects no read strobe and exactly one completion, which carries the indirect target; any completion with an empty scoreboard counts as a failure.

// File: rtl/brt_pkg.sv
`timescale 1ns/1ps
package brt_pkg;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int PAGE_W = ADDR_W - DATA_W;
  localparam logic [PAGE_W-1:0] TABLE_PAGE = PAGE_W'(3);
  localparam logic [DATA_W-1:0] OP_PIND = 8'hB3;
  localparam logic [DATA_W-1:0] OP_TBL  = 8'hE3;
  localparam logic [DATA_W-1:0] OP_SEL0 = 8'hE5;
  localparam logic [DATA_W-1:0] OP_SEL1 = 8'hF5;
  localparam logic [DATA_W-1:0] OP_JTF  = 8'h16;

  typedef enum logic [3:0] {
    K_NONE, K_COND, K_BIT, K_DJNZ, K_LJMP, K_CALL, K_PIND, K_TBL, K_SEL0, K_SEL1
  } kind_t;

  // in-page target: keep page of fall-through address
  function automatic logic [ADDR_W-1:0] short_target(input logic [ADDR_W-1:0] npc,
                                                     input logic [DATA_W-1:0] lo);
    return {npc[ADDR_W-1:DATA_W], lo};
  endfunction

  // long target: bank bit, three opcode bits, second byte
  function automatic logic [ADDR_W-1:0] long_target(input logic bk, input logic [2:0] hi,
                                                    input logic [DATA_W-1:0] lo);
    return {bk, hi, lo};
  endfunction

  function automatic logic [ADDR_W-1:0] table_addr(input logic [DATA_W-1:0] a);
    return {TABLE_PAGE, a};
  endfunction

  function automatic logic cond_code_used(input logic [3:0] nib);
    case (nib)
      4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h7, 4'h8, 4'h9, 4'hB, 4'hC, 4'hE, 4'hF: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic kind_t classify(input logic [DATA_W-1:0] op);
    if (op == OP_PIND) return K_PIND;
    if (op == OP_TBL)  return K_TBL;
    if (op == OP_SEL0) return K_SEL0;
    if (op == OP_SEL1) return K_SEL1;
    if (op[3:0] == 4'h4) return op[4] ? K_CALL : K_LJMP;
    if (op[3:0] == 4'h6) return cond_code_used(op[7:4]) ? K_COND : K_NONE;
    if (op[3:0] == 4'h2 && op[4]) return K_BIT;
    if (op[7:4] == 4'hE && op[3]) return K_DJNZ;
    return K_NONE;
  endfunction
endpackage

// File: rtl/brt_decode.sv
`timescale 1ns/1ps
module brt_decode
  import brt_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [DW-1:0] opcode,
  output kind_t         kind,
  output logic [3:0]    cond_sel,
  output logic [2:0]    bit_sel,
  output logic          is_mem
);
  always_comb begin
    kind     = classify(opcode);
    cond_sel = opcode[7:4];
    bit_sel  = opcode[7:5];
    is_mem   = (kind == K_PIND) || (kind == K_TBL);
  end
endmodule

// File: rtl/brt_cond.sv
`timescale 1ns/1ps
module brt_cond
  import brt_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic [3:0]    cond_sel,
  input  logic [2:0]    bit_sel,
  input  logic [DW-1:0] acc,
  input  logic          carry,
  input  logic          f0,
  input  logic          f1,
  input  logic          tf,
  input  logic          t0_pin,
  input  logic          t1_pin,
  input  logic          int_pin,
  output logic          cond_hit,
  output logic          bit_hit
);
  logic acc_zero;
  assign acc_zero = (acc == '0);
  assign bit_hit  = acc[bit_sel];

  always_comb begin
    case (cond_sel)
      4'h1:    cond_hit = tf;
      4'h2:    cond_hit = !t0_pin;
      4'h3:    cond_hit = t0_pin;
      4'h4:    cond_hit = !t1_pin;
      4'h5:    cond_hit = t1_pin;
      4'h7:    cond_hit = f1;
      4'h8:    cond_hit = !int_pin;
      4'h9:    cond_hit = !acc_zero;
      4'hB:    cond_hit = f0;
      4'hC:    cond_hit = acc_zero;
      4'hE:    cond_hit = !carry;
      4'hF:    cond_hit = carry;
      default: cond_hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/brt_flags.sv
`timescale 1ns/1ps
module brt_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_we,
  input  logic sel_val,
  input  logic tf_set,
  input  logic tf_consume,
  output logic bank,
  output logic tf_flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank    <= 1'b0;
      tf_flag <= 1'b0;
    end else begin
      if (sel_we) bank <= sel_val;
      // a fresh overflow outranks consumption in the same cycle
      if (tf_set)          tf_flag <= 1'b1;
      else if (tf_consume) tf_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/branch_target_unit.sv
`timescale 1ns/1ps
module branch_target_unit
  import brt_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid,
  input  logic [DW-1:0] opcode,
  input  logic [DW-1:0] operand,
  input  logic [AW-1:0] next_pc,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] reg_val,
  input  logic          carry,
  input  logic          f0,
  input  logic          f1,
  input  logic          t0_pin,
  input  logic          t1_pin,
  input  logic          int_pin,
  input  logic          tf_set,
  input  logic [DW-1:0] pmem_data,
  output logic [AW-1:0] pmem_addr,
  output logic          pmem_rd,
  output logic          done,
  output logic [AW-1:0] pc_out,
  output logic          taken,
  output logic          is_call,
  output logic          djnz_wr,
  output logic [DW-1:0] djnz_val,
  output logic          tbl_wr,
  output logic [DW-1:0] tbl_data,
  output logic          bank,
  output logic          tf_flag
);
  kind_t         kind;
  logic [3:0]    cond_sel;
  logic [2:0]    bit_sel;
  logic          is_mem;
  logic          cond_hit, bit_hit;
  logic          busy;
  logic          wait_tbl;
  logic [AW-1:0] wait_pc;

  // named events for the checker
  logic          accept;
  logic          tf_consume;
  logic          sel_we;
  logic [DW-1:0] dec_val;
  logic          imm_take;
  logic [AW-1:0] imm_target;
  logic [AW-1:0] imm_pc;

  brt_decode #(.DW(DW)) u_dec (
    .opcode(opcode), .kind(kind), .cond_sel(cond_sel), .bit_sel(bit_sel), .is_mem(is_mem)
  );

  brt_cond #(.DW(DW)) u_cond (
    .cond_sel(cond_sel), .bit_sel(bit_sel), .acc(acc), .carry(carry), .f0(f0), .f1(f1),
    .tf(tf_flag), .t0_pin(t0_pin), .t1_pin(t1_pin), .int_pin(int_pin),
    .cond_hit(cond_hit), .bit_hit(bit_hit)
  );

  assign accept     = valid && !busy;
  assign tf_consume = accept && (kind == K_COND) && (cond_sel == 4'h1);
  assign sel_we     = accept && ((kind == K_SEL0) || (kind == K_SEL1));

  brt_flags u_flags (
    .clk(clk), .rst_n(rst_n), .sel_we(sel_we), .sel_val(kind == K_SEL1),
    .tf_set(tf_set), .tf_consume(tf_consume), .bank(bank), .tf_flag(tf_flag)
  );

  assign pmem_rd   = accept && is_mem;
  assign pmem_addr = (kind == K_TBL) ? table_addr(acc) : short_target(next_pc, acc);
  assign dec_val   = reg_val - 1'b1;

  always_comb begin
    case (kind)
      K_COND:         imm_take = cond_hit;
      K_BIT:          imm_take = bit_hit;
      K_DJNZ:         imm_take = (dec_val != '0);
      K_LJMP, K_CALL: imm_take = 1'b1;
      default:        imm_take = 1'b0;
    endcase
    if (kind == K_LJMP || kind == K_CALL) imm_target = long_target(bank, opcode[7:5], operand);
    else                                  imm_target = short_target(next_pc, operand);
    imm_pc = imm_take ? imm_target : next_pc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      wait_tbl <= 1'b0;
      wait_pc  <= '0;
      done     <= 1'b0;
      pc_out   <= '0;
      taken    <= 1'b0;
      is_call  <= 1'b0;
      djnz_wr  <= 1'b0;
      djnz_val <= '0;
      tbl_wr   <= 1'b0;
      tbl_data <= '0;
    end else begin
      done    <= 1'b0;
      djnz_wr <= 1'b0;
      tbl_wr  <= 1'b0;
      if (busy) begin
        // memory byte arrives this cycle
        busy    <= 1'b0;
        done    <= 1'b1;
        is_call <= 1'b0;
        if (wait_tbl) begin
          pc_out   <= wait_pc;
          taken    <= 1'b0;
          tbl_wr   <= 1'b1;
          tbl_data <= pmem_data;
        end else begin
          pc_out <= short_target(wait_pc, pmem_data);
          taken  <= 1'b1;
        end
      end else if (accept) begin
        if (is_mem) begin
          busy     <= 1'b1;
          wait_tbl <= (kind == K_TBL);
          wait_pc  <= next_pc;
        end else begin
          done     <= 1'b1;
          pc_out   <= imm_pc;
          taken    <= imm_take;
          is_call  <= (kind == K_CALL);
          djnz_wr  <= (kind == K_DJNZ);
          djnz_val <= dec_val;
        end
      end
    end
  end
endmodule

// File: rtl/brt_chk.sv
`timescale 1ns/1ps
module brt_chk
  import brt_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          accept,
  input logic [DW-1:0] opcode,
  input logic          tf_set,
  input logic          tf_flag,
  input logic          bank,
  input logic          pmem_rd,
  input logic          done,
  input logic          taken,
  input logic          is_call,
  input logic          djnz_wr,
  input logic [DW-1:0] djnz_val,
  input logic          tbl_wr
);
  assert_djnz_branch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && djnz_wr) |-> (taken == (djnz_val != '0)));

  assert_call_taken_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && is_call) |-> taken);

  assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(accept && (opcode == OP_SEL0 || opcode == OP_SEL1)) |=> $stable(bank));

  assert_bank_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && opcode == OP_SEL1) |=> bank);

  assert_read_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pmem_rd |-> ##2 done);

  assert_table_fallthrough_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr |-> (done && !taken));

  assert_tf_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tf_set |=> tf_flag);

  assert_tf_consumed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && opcode == OP_JTF && !tf_set) |=> !tf_flag);

  assert_no_back_to_back_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    pmem_rd |=> !pmem_rd);
endmodule

bind branch_target_unit brt_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .opcode(opcode), .tf_set(tf_set),
  .tf_flag(tf_flag), .bank(bank), .pmem_rd(pmem_rd), .done(done), .taken(taken),
  .is_call(is_call), .djnz_wr(djnz_wr), .djnz_val(djnz_val), .tbl_wr(tbl_wr)
);

// File: tb/sim_branch_target_unit.sv
`timescale 1ns/1ps
module sim_branch_target_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [7:0]  opcode = '0, operand = '0, acc = '0, reg_val = '0, pmem_data = '0;
  logic [11:0] next_pc = '0;
  logic        carry = 0, f0 = 0, f1 = 0, t0_pin = 0, t1_pin = 0, int_pin = 1, tf_set = 0;
  logic [11:0] pmem_addr, pc_out;
  logic        pmem_rd, done, taken, is_call, djnz_wr, tbl_wr, bank, tf_flag;
  logic [7:0]  djnz_val, tbl_data;

  branch_target_unit u0 (
    .clk(clk), .rst_n(rst_n), .valid(valid), .opcode(opcode), .operand(operand),
    .next_pc(next_pc), .acc(acc), .reg_val(reg_val), .carry(carry), .f0(f0), .f1(f1),
    .t0_pin(t0_pin), .t1_pin(t1_pin), .int_pin(int_pin), .tf_set(tf_set),
    .pmem_data(pmem_data), .pmem_addr(pmem_addr), .pmem_rd(pmem_rd), .done(done),
    .pc_out(pc_out), .taken(taken), .is_call(is_call), .djnz_wr(djnz_wr),
    .djnz_val(djnz_val), .tbl_wr(tbl_wr), .tbl_data(tbl_data), .bank(bank), .tf_flag(tf_flag)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    logic [11:0] pc;
    logic        tk;
    logic        cl;
    logic        dw;
    logic [7:0]  dv;
    logic        tw;
    logic [7:0]  td;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   finished = 0;

  function automatic logic [7:0] rom(input logic [11:0] a);
    return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
  endfunction

  always @(posedge clk) if (pmem_rd) pmem_data <= rom(pmem_addr);

  task automatic check_eq(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic exp_t mk(input logic [11:0] pc, input logic tk, input logic cl,
                              input logic dw, input logic [7:0] dv, input logic tw,
                              input logic [7:0] td, input string tag);
    exp_t e;
    e.pc = pc; e.tk = tk; e.cl = cl; e.dw = dw; e.dv = dv; e.tw = tw; e.td = td; e.tag = tag;
    return e;
  endfunction

  // monitor: compare each completion against the scoreboard front
  always @(negedge clk) begin
    if (rst_n && done && !finished) begin
      if (q.size() == 0) check_eq("R11", "unexpected done", 1, 0);
      else begin
        exp_t e;
        e = q.pop_front();
        check_eq(e.tag, "pc_out", pc_out, e.pc);
        check_eq(e.tag, "taken", taken, e.tk);
        check_eq(e.tag, "is_call", is_call, e.cl);
        check_eq(e.tag, "djnz_wr", djnz_wr, e.dw);
        check_eq(e.tag, "tbl_wr", tbl_wr, e.tw);
        if (e.dw) check_eq(e.tag, "djnz_val", djnz_val, e.dv);
        if (e.tw) check_eq(e.tag, "tbl_data", tbl_data, e.td);
      end
    end
  end

  task automatic issue(input logic [7:0] op, input logic [7:0] opnd, input logic [11:0] npc,
                       input logic [7:0] a, input logic [7:0] rv, input bit tfs,
                       input bit mem, input exp_t e);
    @(negedge clk);
    valid = 1; opcode = op; operand = opnd; next_pc = npc; acc = a; reg_val = rv; tf_set = tfs;
    q.push_back(e);
    @(negedge clk);
    valid = 0; tf_set = 0;
    if (mem) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #100000;
    check_eq("WD", "watchdog expired", 1, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check_eq("R1", "done", done, 0);
    check_eq("R1", "bank", bank, 0);
    check_eq("R1", "tf_flag", tf_flag, 0);
    check_eq("R1", "pmem_rd", pmem_rd, 0);
    rst_n = 1;

    // R2 condition codes
    carry = 1;
    issue(8'hF6, 8'h12, 12'h345, 8'h00, 8'h00, 0, 0, mk(12'h312, 1, 0, 0, 0, 0, 0, "R2"));
    carry = 0;
    issue(8'hF6, 8'h12, 12'h345, 8'h00, 8'h00, 0, 0, mk(12'h345, 0, 0, 0, 0, 0, 0, "R2"));
    issue(8'hE6, 8'h9A, 12'h7F0, 8'h00, 8'h00, 0, 0, mk(12'h79A, 1, 0, 0, 0, 0, 0, "R2"));
    issue(8'hC6, 8'h33, 12'h101, 8'h00, 8'h00, 0, 0, mk(12'h133, 1, 0, 0, 0, 0, 0, "R2"));
    issue(8'h96, 8'h33, 12'h101, 8'h00, 8'h00, 0, 0, mk(12'h101, 0, 0, 0, 0, 0, 0, "R2"));
    issue(8'h96, 8'h44, 12'hA20, 8'h07, 8'h00, 0, 0, mk(12'hA44, 1, 0, 0, 0, 0, 0, "R2"));
    t0_pin = 1; t1_pin = 0; int_pin = 0; f1 = 0; f0 = 1;
    issue(8'h36, 8'h01, 12'h200, 8'h00, 8'h00, 0, 0, mk(12'h201, 1, 0, 0, 0, 0, 0, "R2"));
    issue(8'h26, 8'h01, 12'h200, 8'h00, 8'h00, 0, 0, mk(12'h200, 0, 0, 0, 0, 0, 0, "R2"));
    issue(8'h46, 8'h02, 12'h200, 8'h00, 8'h00, 0, 0, mk(12'h202, 1, 0, 0, 0, 0, 0, "R2"));
    issue(8'h56, 8'h02, 12'h200, 8'h00, 8'h00, 0, 0, mk(12'h200, 0, 0, 0, 0, 0, 0, "R2"));
    issue(8'h86, 8'h03, 12'h200, 8'h00, 8'h00, 0, 0, mk(12'h203, 1, 0, 0, 0, 0, 0, "R2"));
    issue(8'h76, 8'h04, 12'h200, 8'h00, 8'h00, 0, 0, mk(12'h200, 0, 0, 0, 0, 0, 0, "R2"));
    issue(8'hB6, 8'h05, 12'h200, 8'h00, 8'h00, 0, 0, mk(12'h205, 1, 0, 0, 0, 0, 0, "R2"));
    int_pin = 1;

    // R3 accumulator bit test, bit 5 then bit 0
    issue(8'hB2, 8'hC0, 12'h5FF, 8'h20, 8'h00, 0, 0, mk(12'h5C0, 1, 0, 0, 0, 0, 0, "R3"));
    issue(8'hB2, 8'hC0, 12'h5FF, 8'hDF, 8'h00, 0, 0, mk(12'h5FF, 0, 0, 0, 0, 0, 0, "R3"));
    issue(8'h12, 8'h08, 12'h030, 8'h01, 8'h00, 0, 0, mk(12'h008, 1, 0, 0, 0, 0, 0, "R3"));

    // R4 decrement and branch, including wrap from 0
    issue(8'hEA, 8'h50, 12'h410, 8'h00, 8'h02, 0, 0, mk(12'h450, 1, 0, 1, 8'h01, 0, 0, "R4"));
    issue(8'hEF, 8'h50, 12'h410, 8'h00, 8'h01, 0, 0, mk(12'h410, 0, 0, 1, 8'h00, 0, 0, "R4"));
    issue(8'hE8, 8'h60, 12'h410, 8'h00, 8'h00, 0, 0, mk(12'h460, 1, 0, 1, 8'hFF, 0, 0, "R4"));

    // R5 / R6 long jumps and calls with both bank values
    issue(8'hA4, 8'h77, 12'h123, 8'h00, 8'h00, 0, 0, mk(12'h577, 1, 0, 0, 0, 0, 0, "R5"));
    issue(8'hF5, 8'h00, 12'h124, 8'h00, 8'h00, 0, 0, mk(12'h124, 0, 0, 0, 0, 0, 0, "R6"));
    check_eq("R6", "bank after F5", bank, 1);
    issue(8'hA4, 8'h77, 12'h125, 8'h00, 8'h00, 0, 0, mk(12'hD77, 1, 0, 0, 0, 0, 0, "R5"));
    issue(8'h34, 8'h0F, 12'h126, 8'h00, 8'h00, 0, 0, mk(12'h90F, 1, 1, 0, 0, 0, 0, "R5"));
    issue(8'hE5, 8'h00, 12'h127, 8'h00, 8'h00, 0, 0, mk(12'h127, 0, 0, 0, 0, 0, 0, "R6"));
    check_eq("R6", "bank after E5", bank, 0);
    issue(8'hF4, 8'hAB, 12'h128, 8'h00, 8'h00, 0, 0, mk(12'h7AB, 1, 1, 0, 0, 0, 0, "R5"));

    // R7 page-indirect jump, R8 table read
    issue(8'hB3, 8'h00, 12'h6C0, 8'h3D, 8'h00, 0, 1,
          mk({4'h6, rom(12'h63D)}, 1, 0, 0, 0, 0, 0, "R7"));
    issue(8'hE3, 8'h00, 12'hC44, 8'h81, 8'h00, 0, 1,
          mk(12'hC44, 0, 0, 0, 0, 1, rom(12'h381), "R8"));

    // R10 opcodes outside the handled set
    issue(8'h00, 8'h11, 12'h050, 8'h00, 8'h05, 0, 0, mk(12'h050, 0, 0, 0, 0, 0, 0, "R10"));
    issue(8'h06, 8'h11, 12'h051, 8'h00, 8'h05, 0, 0, mk(12'h051, 0, 0, 0, 0, 0, 0, "R10"));
    issue(8'h83, 8'h11, 12'h052, 8'h00, 8'h05, 0, 0, mk(12'h052, 0, 0, 0, 0, 0, 0, "R10"));

    // R11 a valid during the wait cycle is dropped
    @(negedge clk);
    valid = 1; opcode = 8'hB3; next_pc = 12'h2C0; acc = 8'h10;
    q.push_back(mk({4'h2, rom(12'h210)}, 1, 0, 0, 0, 0, 0, "R7"));
    #1;
    check_eq("R7", "pmem_rd in accept cycle", pmem_rd, 1);
    check_eq("R7", "pmem_addr", pmem_addr, 12'h210);
    @(negedge clk);
    opcode = 8'h04; operand = 8'h55;
    #1;
    check_eq("R11", "pmem_rd during wait", pmem_rd, 0);
    @(negedge clk);
    valid = 0;
    repeat (3) @(negedge clk);

    // R9 timer flag: pulse, consume, then collision with a pulse
    tf_set = 1;
    @(negedge clk);
    tf_set = 0;
    check_eq("R9", "tf_flag after pulse", tf_flag, 1);
    issue(8'h16, 8'h40, 12'h100, 8'h00, 8'h00, 0, 0, mk(12'h140, 1, 0, 0, 0, 0, 0, "R9"));
    check_eq("R9", "tf_flag after test", tf_flag, 0);
    issue(8'h16, 8'h40, 12'h100, 8'h00, 8'h00, 1, 0, mk(12'h100, 0, 0, 0, 0, 0, 0, "R9"));
    check_eq("R9", "tf_flag kept by same-cycle pulse", tf_flag, 1);
    issue(8'h16, 8'h41, 12'h100, 8'h00, 8'h00, 0, 0, mk(12'h141, 1, 0, 0, 0, 0, 0, "R9"));
    check_eq("R9", "tf_flag consumed", tf_flag, 0);

    repeat (4) @(negedge clk);
    check_eq("R11", "scoreboard drained", q.size(), 0);
    finish_run();
  end
endmodule